// File: doc/BRIEF.md
# Serial Controller FIFO Interrupt and Status Unit

This unit produces the interrupt and status bits for a serial controller that has a transmit FIFO and a receive FIFO. It compares the two fill levels against programmable thresholds. It also latches three error events: a push into a full transmit FIFO, a pop from an empty receive FIFO, and a frame that arrives while the receive FIFO is full.

Five sources feed a raw status vector. A per-source mask selects which of them reach the masked status vector. The single interrupt line is the OR of the masked bits.

The threshold bits follow the FIFO levels and are not latched. The error bits are sticky. A read strobe on the clear register removes them, and so does disabling the controller.

The status vector uses these bit positions:

| Bit | Source |
|-----|--------|
| 0 | Transmit low |
| 1 | Transmit overflow |
| 2 | Receive underflow |
| 3 | Receive overflow |
| 4 | Receive high |

Top module: `spi_irq_unit`

## Requirements
- R1: While reset is asserted, both thresholds, the mask and the raw status read as zero, and the interrupt line is low.
- R2: Raw bit 0 (transmit low) is 1 in the cycle after a cycle in which tx_level is less than or equal to tx_thr, and 0 otherwise.
- R3: Raw bit 4 (receive high) is 1 in the cycle after a cycle in which rx_level is strictly greater than rx_thr. A threshold of L-1 therefore fires once L entries are present.
- R4: A threshold write keeps only the low $clog2(DEPTH) bits of thr_wdata. The stored value appears on tx_thr or rx_thr one cycle after the write.
- R5: Raw bit 1 (transmit overflow) becomes 1 one cycle after a cycle with tx_push and tx_full both high and enable high. It then stays 1.
- R6: Raw bit 2 (receive underflow) becomes 1 one cycle after a cycle with rx_pop and rx_empty both high and enable high. It then stays 1.
- R7: Raw bit 3 (receive overflow) becomes 1 one cycle after a cycle with rx_arrive and rx_full both high and enable high. It then stays 1.
- R8: A clr_rd pulse clears raw bits 1 to 3 one cycle later. If a bit's setting event occurs in the same cycle as clr_rd, that bit stays 1.
- R9: While enable is low, raw bits 1 to 3 read 0 from the next cycle on, and events are ignored. Raw bits 0 and 4 keep following the levels.
- R10: A mask write takes effect one cycle later. irq_stat is raw_stat ANDed with mask_q, so a zero mask blocks every source.
- R11: irq is high exactly when any bit of irq_stat is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low clears and holds the error flags |
| tx_level | input | $clog2(DEPTH+1) | Transmit FIFO fill level |
| rx_level | input | $clog2(DEPTH+1) | Receive FIFO fill level |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full flag |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty flag |
| rx_arrive | input | 1 | A received frame is being stored |
| rx_full | input | 1 | Receive FIFO full flag |
| thr_wr_tx | input | 1 | Write strobe for the transmit threshold |
| thr_wr_rx | input | 1 | Write strobe for the receive threshold |
| thr_wdata | input | WDATA_W | Threshold write data |
| mask_wr | input | 1 | Write strobe for the mask |
| mask_wdata | input | 5 | Mask write data; 1 enables a source |
| clr_rd | input | 1 | Read strobe of the clear register |
| tx_thr | output | $clog2(DEPTH) | Stored transmit threshold |
| rx_thr | output | $clog2(DEPTH) | Stored receive threshold |
| mask_q | output | 5 | Stored mask |
| raw_stat | output | 5 | Raw status, unaffected by the mask |
| irq_stat | output | 5 | Masked status |
| irq | output | 1 | Combined interrupt line |

## Verification
The assertions check the following relations on every cycle:
- the one-cycle latency from a level comparison to its threshold bit;
- the setting of each error flag by its event;
- the clearing by clr_rd when no event occurs in the same cycle;
- the flush while disabled;
- the silence of the interrupt line under a zero mask;
- the truncation of threshold writes.

Other behaviours are shown only by the bench's scenarios and its cycle-accurate model:
- that sticky flags persist across many idle cycles;
- that a set wins over a simultaneous clear;
- that the receive threshold fires exactly when the level reaches threshold plus one;
- that the masked view tracks arbitrary mixes of mask and raw bits.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSRC = 5;

  typedef enum int {
    SRC_TXLOW  = 0,
    SRC_TXOVF  = 1,
    SRC_RXUND  = 2,
    SRC_RXOVF  = 3,
    SRC_RXHIGH = 4
  } src_e;

  typedef logic [NSRC-1:0] src_vec_t;

  localparam int NSTICKY = 3;
endpackage

// File: rtl/spi_irq_thresh.sv
// Threshold register plus level comparison. CMP_ABOVE selects the sense:
// 0 -> hit when level <= threshold, 1 -> hit when level > threshold.
module spi_irq_thresh #(
  parameter int DEPTH     = 16,
  parameter int WDATA_W   = 8,
  parameter bit CMP_ABOVE = 1'b0,
  localparam int LVL_W    = $clog2(DEPTH + 1),
  localparam int THR_W    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WDATA_W-1:0] wdata,
  input  logic [LVL_W-1:0]   level,
  output logic [THR_W-1:0]   thr_q,
  output logic               hit
);
  logic [THR_W-1:0] thr_d;
  logic [LVL_W-1:0] thr_ext;

  // Only the low bits are kept, so larger values cannot be stored.
  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = wdata[THR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     thr_q <= '0;
    else if (wr_en) thr_q <= thr_d;
  end

  assign thr_ext = LVL_W'(thr_q);

  generate
    if (CMP_ABOVE) begin : g_above
      assign hit = (level > thr_ext);
    end else begin : g_at_or_below
      assign hit = (level <= thr_ext);
    end
  endgenerate
endmodule

// File: rtl/spi_irq_sticky.sv
// One sticky error flag: set wins over clear, disable flushes.
module spi_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic event_i,
  input  logic clear_i,
  output logic flag_q
);
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_d = flag_q;
    if (!enable)      flag_d = 1'b0;
    else if (event_i) flag_d = 1'b1;
    else if (clear_i) flag_d = 1'b0;
  end

  assign flag_ce = (!enable) || event_i || clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end
endmodule

// File: rtl/spi_irq_mask.sv
// Mask register, masked status view and the combined interrupt line.
module spi_irq_mask
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  src_vec_t wdata,
  input  src_vec_t raw,
  output src_vec_t mask_q,
  output src_vec_t masked,
  output logic     irq
);
  src_vec_t mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_d;
  end

  assign masked = raw & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int WDATA_W  = 8,
  localparam int LVL_W   = $clog2(DEPTH + 1),
  localparam int THR_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               tx_push,
  input  logic               tx_full,
  input  logic               rx_pop,
  input  logic               rx_empty,
  input  logic               rx_arrive,
  input  logic               rx_full,
  input  logic               thr_wr_tx,
  input  logic               thr_wr_rx,
  input  logic [WDATA_W-1:0] thr_wdata,
  input  logic               mask_wr,
  input  logic [NSRC-1:0]    mask_wdata,
  input  logic               clr_rd,
  output logic [THR_W-1:0]   tx_thr,
  output logic [THR_W-1:0]   rx_thr,
  output logic [NSRC-1:0]    mask_q,
  output logic [NSRC-1:0]    raw_stat,
  output logic [NSRC-1:0]    irq_stat,
  output logic               irq
);
  logic tx_hit;
  logic rx_hit;
  logic txlow_d, txlow_q;
  logic rxhigh_d, rxhigh_q;
  logic [NSTICKY-1:0] err_evt;
  logic [NSTICKY-1:0] err_q;
  src_vec_t raw_vec;

  spi_irq_thresh #(.DEPTH(DEPTH), .WDATA_W(WDATA_W), .CMP_ABOVE(1'b0)) u_tx_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_tx), .wdata(thr_wdata),
    .level(tx_level), .thr_q(tx_thr), .hit(tx_hit)
  );

  spi_irq_thresh #(.DEPTH(DEPTH), .WDATA_W(WDATA_W), .CMP_ABOVE(1'b1)) u_rx_thr (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_rx), .wdata(thr_wdata),
    .level(rx_level), .thr_q(rx_thr), .hit(rx_hit)
  );

  // Level-following threshold bits, registered once.
  always_comb begin
    txlow_d  = tx_hit;
    rxhigh_d = rx_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txlow_q  <= 1'b0;
      rxhigh_q <= 1'b0;
    end else begin
      txlow_q  <= txlow_d;
      rxhigh_q <= rxhigh_d;
    end
  end

  // Error events, in sticky-flag order: tx overflow, rx underflow, rx overflow.
  assign err_evt[0] = tx_push   & tx_full;
  assign err_evt[1] = rx_pop    & rx_empty;
  assign err_evt[2] = rx_arrive & rx_full;

  generate
    for (genvar i = 0; i < NSTICKY; i++) begin : g_err
      spi_irq_sticky u_flag (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .event_i(err_evt[i]), .clear_i(clr_rd), .flag_q(err_q[i])
      );
    end
  endgenerate

  always_comb begin
    raw_vec             = '0;
    raw_vec[SRC_TXLOW]  = txlow_q;
    raw_vec[SRC_TXOVF]  = err_q[0];
    raw_vec[SRC_RXUND]  = err_q[1];
    raw_vec[SRC_RXOVF]  = err_q[2];
    raw_vec[SRC_RXHIGH] = rxhigh_q;
  end

  assign raw_stat = raw_vec;

  spi_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(mask_wdata),
    .raw(raw_vec), .mask_q(mask_q), .masked(irq_stat), .irq(irq)
  );
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk #(
  parameter int DEPTH   = 16,
  parameter int WDATA_W = 8,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int THR_W  = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic [LVL_W-1:0]   tx_level,
  input logic [LVL_W-1:0]   rx_level,
  input logic               tx_push,
  input logic               tx_full,
  input logic               rx_pop,
  input logic               rx_empty,
  input logic               rx_arrive,
  input logic               rx_full,
  input logic               thr_wr_tx,
  input logic [WDATA_W-1:0] thr_wdata,
  input logic               clr_rd,
  input logic [THR_W-1:0]   tx_thr,
  input logic [THR_W-1:0]   rx_thr,
  input logic [4:0]         mask_q,
  input logic [4:0]         raw_stat,
  input logic               irq
);
  logic [THR_W-1:0] wd_trunc;
  assign wd_trunc = thr_wdata[THR_W-1:0];

  a_r2_tx_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(tx_thr)) |=> raw_stat[0]);

  a_r3_rx_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level > LVL_W'(rx_thr)) |=> raw_stat[4]);

  a_r4_thr_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr_tx |=> (tx_thr == $past(wd_trunc)));

  a_r5_tx_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_push && tx_full) |=> raw_stat[1]);

  a_r6_rx_und: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_pop && rx_empty) |=> raw_stat[2]);

  a_r7_rx_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rx_arrive && rx_full) |=> raw_stat[3]);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr_rd && !(tx_push && tx_full)) |=> !raw_stat[1]);

  a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (raw_stat[3:1] == 3'b000));

  a_r10_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 5'b0) |-> !irq);
endmodule

bind spi_irq_unit spi_irq_chk #(.DEPTH(DEPTH), .WDATA_W(WDATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_push(tx_push), .tx_full(tx_full),
  .rx_pop(rx_pop), .rx_empty(rx_empty),
  .rx_arrive(rx_arrive), .rx_full(rx_full),
  .thr_wr_tx(thr_wr_tx), .thr_wdata(thr_wdata), .clr_rd(clr_rd),
  .tx_thr(tx_thr), .rx_thr(rx_thr), .mask_q(mask_q),
  .raw_stat(raw_stat), .irq(irq)
);

// File: tb/spi_irq_unit_bench.sv
`timescale 1ns/1ps
module spi_irq_unit_bench;
  localparam int DEPTH   = 16;
  localparam int WDATA_W = 8;
  localparam int LVL_W   = $clog2(DEPTH + 1);
  localparam int THR_W   = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic tx_push, tx_full, rx_pop, rx_empty, rx_arrive, rx_full;
  logic thr_wr_tx, thr_wr_rx;
  logic [WDATA_W-1:0] thr_wdata;
  logic mask_wr;
  logic [4:0] mask_wdata;
  logic clr_rd;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [4:0] mask_q, raw_stat, irq_stat;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [THR_W-1:0] m_txthr, m_rxthr;
  logic [4:0] m_mask, m_raw;

  always #2.5 clk = ~clk;

  spi_irq_unit u_spi_irq_unit (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .tx_full(tx_full), .rx_pop(rx_pop), .rx_empty(rx_empty),
    .rx_arrive(rx_arrive), .rx_full(rx_full),
    .thr_wr_tx(thr_wr_tx), .thr_wr_rx(thr_wr_rx), .thr_wdata(thr_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .clr_rd(clr_rd),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask_q(mask_q),
    .raw_stat(raw_stat), .irq_stat(irq_stat), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic sticky_next(logic old, logic ev, logic clr, logic en);
    if (!en) return 1'b0;
    if (ev) return 1'b1;
    if (clr) return 1'b0;
    return old;
  endfunction

  task automatic idle_inputs();
    tx_push = 0; tx_full = 0; rx_pop = 0; rx_empty = 0;
    rx_arrive = 0; rx_full = 0; thr_wr_tx = 0; thr_wr_rx = 0;
    mask_wr = 0; clr_rd = 0;
  endtask

  task automatic compare_all();
    chk("R2 tx low",      int'(raw_stat[0]), int'(m_raw[0]));
    chk("R5 tx overflow", int'(raw_stat[1]), int'(m_raw[1]));
    chk("R6 rx underflow",int'(raw_stat[2]), int'(m_raw[2]));
    chk("R7 rx overflow", int'(raw_stat[3]), int'(m_raw[3]));
    chk("R3 rx high",     int'(raw_stat[4]), int'(m_raw[4]));
    chk("R4 tx thr",      int'(tx_thr), int'(m_txthr));
    chk("R4 rx thr",      int'(rx_thr), int'(m_rxthr));
    chk("R10 mask",       int'(mask_q), int'(m_mask));
    chk("R10 irq_stat",   int'(irq_stat), int'(m_raw & m_mask));
    chk("R11 irq",        int'(irq), int'(|(m_raw & m_mask)));
  endtask

  // One clock: model the edge with the inputs driven before it, compare at negedge.
  task automatic cyc();
    logic [4:0] nr;
    @(posedge clk);
    nr[0] = (tx_level <= LVL_W'(m_txthr));
    nr[4] = (rx_level > LVL_W'(m_rxthr));
    nr[1] = sticky_next(m_raw[1], tx_push & tx_full, clr_rd, enable);
    nr[2] = sticky_next(m_raw[2], rx_pop & rx_empty, clr_rd, enable);
    nr[3] = sticky_next(m_raw[3], rx_arrive & rx_full, clr_rd, enable);
    m_raw = nr;
    if (thr_wr_tx) m_txthr = thr_wdata[THR_W-1:0];
    if (thr_wr_rx) m_rxthr = thr_wdata[THR_W-1:0];
    if (mask_wr) m_mask = mask_wdata;
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    rst_n = 0; enable = 1; tx_level = 0; rx_level = 0; thr_wdata = 0; mask_wdata = 0;
    idle_inputs();
    m_txthr = 0; m_rxthr = 0; m_mask = 0; m_raw = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 raw", int'(raw_stat), 0);
    chk("R1 mask", int'(mask_q), 0);
    chk("R1 thr", int'({tx_thr, rx_thr}), 0);
    chk("R1 irq", int'(irq), 0);
    rst_n = 1;
    @(negedge clk);
    m_raw = 0;

    // R4: write above depth truncates
    thr_wdata = 8'h3B; thr_wr_tx = 1; cyc();
    chk("R4 truncated tx thr", int'(tx_thr), 8'h3B % DEPTH);
    // R3: rx threshold 3 fires at level 4, not 3
    thr_wdata = 8'd3; thr_wr_rx = 1; cyc();
    mask_wdata = 5'h1F; mask_wr = 1; cyc();
    rx_level = 3; cyc(); cyc();
    chk("R3 not at threshold", int'(raw_stat[4]), 0);
    rx_level = 4; cyc();
    chk("R3 threshold plus one", int'(raw_stat[4]), 1);
    // R2: at-or-below transmit threshold (11)
    tx_level = 11; cyc();
    chk("R2 at threshold", int'(raw_stat[0]), 1);
    tx_level = 12; cyc();
    chk("R2 above threshold", int'(raw_stat[0]), 0);
    // R5 sticky, R8 clear, set wins over clear
    tx_push = 1; tx_full = 1; cyc();
    repeat (4) cyc();
    chk("R5 sticky", int'(raw_stat[1]), 1);
    tx_push = 1; tx_full = 1; clr_rd = 1; cyc();
    chk("R8 set wins", int'(raw_stat[1]), 1);
    clr_rd = 1; cyc();
    chk("R8 cleared", int'(raw_stat[1]), 0);
    // R6, R7 then R9 disable flush and ignore
    rx_pop = 1; rx_empty = 1; rx_arrive = 1; rx_full = 1; cyc();
    chk("R6 set", int'(raw_stat[2]), 1);
    chk("R7 set", int'(raw_stat[3]), 1);
    enable = 0; rx_pop = 1; rx_empty = 1; cyc();
    chk("R9 flushed", int'(raw_stat[3:1]), 0);
    chk("R9 level bit kept", int'(raw_stat[4]), 1);
    enable = 1;
    // R10: zero mask blocks all
    tx_push = 1; tx_full = 1; mask_wdata = 0; mask_wr = 1; cyc();
    chk("R10 mask zero irq", int'(irq), 0);
    chk("R10 raw still visible", int'(raw_stat[1]), 1);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      enable     = ($urandom % 16) != 0;
      tx_level   = LVL_W'($urandom % (DEPTH + 1));
      rx_level   = LVL_W'($urandom % (DEPTH + 1));
      tx_push    = $urandom % 2; tx_full  = ($urandom % 6) == 0;
      rx_pop     = $urandom % 2; rx_empty = ($urandom % 6) == 0;
      rx_arrive  = $urandom % 2; rx_full  = ($urandom % 6) == 0;
      clr_rd     = ($urandom % 5) == 0;
      thr_wdata  = WDATA_W'($urandom);
      thr_wr_tx  = ($urandom % 10) == 0;
      thr_wr_rx  = ($urandom % 10) == 0;
      mask_wdata = 5'($urandom);
      mask_wr    = ($urandom % 8) == 0;
      cyc();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule